// File: doc/BRIEF.md
# Linked-List Page Table Initializer

This block fills the page-link table of a transmit packet buffer after a single start pulse. Each table entry holds the index of the page that follows it. Pages below a programmable boundary form a linear chain whose final page carries an end marker. Pages from the boundary up to the last table index form a circular ring whose last entry points back at the boundary page.

The table is reached through a command/status write port. The sequencer visits the entries in ascending address order. For each entry it issues one command word that packs an opcode, the data and the address. It then reads the port's 2-bit status once per cycle until the status reports idle, and only then moves to the next entry. If one write stays busy for longer than a parameterised number of polls, the sequencer sets an error flag and gives up the rest of the table. A one-cycle done pulse closes the run whether it succeeded or failed.

Top module: `pglink_init`

## Requirements
- R1: After reset, busy, done, err and tbl_we are all 0.
- R2: Every accepted start makes exactly LAST_IDX+1 writes on a fault-free port, at addresses 0, 1, 2 ... LAST_IDX in that order. Each write is a one-cycle tbl_we pulse with tbl_cmd = {opcode[17:16] = 2'b01 (write), data[15:8], address[7:0]}.
- R3: With boundary b (latched at start), each entry i with i+1 < b is written with i+1.
- R4: Entry b-1 is written with the end marker 0xFF when b is at least 1.
- R5: Each entry i with b <= i < LAST_IDX is written with i+1, and entry LAST_IDX is written with b.
- R6: After a write, no further write is issued until tbl_status has been read as idle (2'b00). Any other value means the write is still in progress.
- R7: If the status is read as non-idle on POLL_LIMIT+1 consecutive polls of one write, err is set, no further write is issued, and done pulses.
- R8: The poll count restarts for every write, so writes that each stay busy for exactly POLL_LIMIT polls complete the whole table without error.
- R9: A start that arrives while busy is 1 is ignored. The running sequence keeps its latched boundary and its address order.
- R10: done is high for exactly one cycle at the end of a run, and busy is 0 in that cycle. err keeps its value until the next accepted start clears it.
- R11: With boundary 0 the whole table is a ring. Entry i gets i+1 for i < LAST_IDX, and entry LAST_IDX gets 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fill pass; ignored while busy |
| boundary | input | 8 | First ring page; chain occupies pages below it |
| tbl_status | input | 2 | Table port status, 2'b00 = idle |
| busy | output | 1 | Fill pass in progress |
| done | output | 1 | One-cycle pulse at end of pass |
| err | output | 1 | Pass abandoned after a poll timeout |
| tbl_we | output | 1 | Command strobe to the table port |
| tbl_cmd | output | 18 | Command word {opcode, data, address} |

## Verification
The embedded properties watch, cycle by cycle, the single-cycle shape of the write strobe and of done. They also check that busy never falls without done, that no command follows an abandoned pass, and that the poll counter never passes its limit. The data written to each entry (the chain values, the end marker, the ring closure and the boundary-zero case), the strict address order, the waiting on a slow port, the timeout threshold against per-write counting, and the ignored restart can only be shown by the bench. Its port model records every command and varies the port latency from run to run.

// File: rtl/pglink_pkg.sv
package pglink_pkg;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] ST_IDLE  = 2'b00;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_SETTLE,
    S_POLL
  } seq_state_t;
endpackage

// File: rtl/pglink_entry_gen.sv
module pglink_entry_gen #(
  parameter int ADDR_W   = 8,
  parameter int LAST_IDX = 255
) (
  input  logic [ADDR_W-1:0] idx,
  input  logic [ADDR_W-1:0] bnd,
  output logic [ADDR_W-1:0] data
);
  localparam logic [ADDR_W-1:0] END_MARK = '1;
  localparam logic [ADDR_W-1:0] LAST_C   = ADDR_W'(LAST_IDX);

  logic [ADDR_W:0] nxt;

  always_comb begin
    nxt = {1'b0, idx} + 1'b1;
    if ({1'b0, idx} < {1'b0, bnd}) begin
      // chain region: final chain page terminates the list
      data = (nxt == {1'b0, bnd}) ? END_MARK : nxt[ADDR_W-1:0];
    end else if (idx == LAST_C) begin
      // ring closure back to the first ring page
      data = bnd;
    end else begin
      data = nxt[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/pglink_poll.sv
module pglink_poll #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic check,
  input  logic st_idle,
  output logic ok,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      cnt <= '0;
    end else if (check && !st_idle && cnt != LIM_C) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ok      = check && st_idle;
  assign expired = check && !st_idle && (cnt == LIM_C);

  // R7: counter saturates at the limit
  p_cnt_cap_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM_C);
endmodule

// File: rtl/pglink_init.sv
module pglink_init
  import pglink_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LAST_IDX   = 255,
  parameter int POLL_LIMIT = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     boundary,
  input  logic [1:0]            tbl_status,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic                  tbl_we,
  output logic [2*ADDR_W+1:0]   tbl_cmd
);
  localparam logic [ADDR_W-1:0] LAST_C = ADDR_W'(LAST_IDX);

  seq_state_t        state;
  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] bnd_q;
  logic [ADDR_W-1:0] gen_data;
  logic              poll_ok;
  logic              poll_exp;

  pglink_entry_gen #(.ADDR_W(ADDR_W), .LAST_IDX(LAST_IDX)) u_gen (
    .idx  (idx),
    .bnd  (bnd_q),
    .data (gen_data)
  );

  pglink_poll #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk     (clk),
    .rst     (rst),
    .arm     (state == S_ISSUE),
    .check   (state == S_POLL),
    .st_idle (tbl_status == ST_IDLE),
    .ok      (poll_ok),
    .expired (poll_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      idx     <= '0;
      bnd_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      tbl_we  <= 1'b0;
      tbl_cmd <= '0;
    end else begin
      done   <= 1'b0;
      tbl_we <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            bnd_q <= boundary;
            idx   <= '0;
            err   <= 1'b0;
            busy  <= 1'b1;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          tbl_we  <= 1'b1;
          tbl_cmd <= {OP_WRITE, gen_data, idx};
          state   <= S_SETTLE;
        end
        S_SETTLE: state <= S_POLL;
        S_POLL: begin
          if (poll_ok) begin
            if (idx == LAST_C) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_ISSUE;
            end
          end else if (poll_exp) begin
            err   <= 1'b1;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: a write strobe is never followed directly by another
  p_single_we_r6: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> !tbl_we);
  // R10: done is a one-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: busy is low while done is shown
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: busy only ends through a done pulse
  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R7: nothing is written once a pass has been abandoned
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (err && !busy) |-> !tbl_we);
endmodule

// File: tb/sim_pglink_init.sv
module sim_pglink_init;
  localparam int LIMIT = 16;
  localparam int NENT  = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  boundary = '0;
  logic [1:0]  tbl_status;
  logic        busy, done, err, tbl_we;
  logic [17:0] tbl_cmd;

  int checks = 0;
  int errors = 0;

  // port model controls and records
  int   lat = 0;
  bit   stuck = 1'b0;
  bit   clr = 1'b0;
  int   busy_cnt = 0;
  int   wr_cnt = 0;
  int   order_bad = 0;
  int   op_bad = 0;
  int   early_bad = 0;
  logic [7:0] mem [NENT];

  always #5 clk = ~clk;

  pglink_init #(.ADDR_W(8), .LAST_IDX(255), .POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .start(start), .boundary(boundary),
    .tbl_status(tbl_status), .busy(busy), .done(done), .err(err),
    .tbl_we(tbl_we), .tbl_cmd(tbl_cmd)
  );

  assign tbl_status = (stuck || busy_cnt != 0) ? 2'b01 : 2'b00;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NENT; i++) mem[i] <= 8'h5A;
      wr_cnt <= 0; order_bad <= 0; op_bad <= 0; early_bad <= 0;
      busy_cnt <= 0;
    end else if (tbl_we) begin
      mem[tbl_cmd[7:0]] <= tbl_cmd[15:8];
      if (int'(tbl_cmd[7:0]) != wr_cnt) order_bad <= order_bad + 1;
      if (tbl_cmd[17:16] != 2'b01) op_bad <= op_bad + 1;
      if (tbl_status != 2'b00) early_bad <= early_bad + 1;
      wr_cnt   <= wr_cnt + 1;
      busy_cnt <= lat;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_val(input int i, input int b);
    if (i < b) return (i + 1 == b) ? 255 : i + 1;
    if (i == 255) return b;
    return i + 1;
  endfunction

  task automatic clear_model();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic pulse_start(input int b);
    @(negedge clk); boundary = 8'(b); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit seen_busy_low);
    int n = 0;
    seen_busy_low = 1'b0;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(done, "R10 done seen (watchdog)", int'(done), 1);
    seen_busy_low = !busy;
    @(negedge clk);
    chk(!done, "R10 done one cycle", int'(done), 0);
  endtask

  task automatic check_table(input int b);
    int bad3 = 0, bad4 = 0, bad5 = 0;
    for (int i = 0; i < NENT; i++) begin
      if (int'(mem[i]) != exp_val(i, b)) begin
        if (i + 1 < b) bad3++;
        else if (i + 1 == b) bad4++;
        else bad5++;
      end
    end
    chk(bad3 == 0, "R3 chain entries", bad3, 0);
    chk(bad4 == 0, "R4 end marker", bad4, 0);
    chk(bad5 == 0, "R5 ring entries", bad5, 0);
  endtask

  task automatic run_full(input int b, input int l, input string name);
    bit bl;
    lat = l; stuck = 1'b0;
    clear_model();
    pulse_start(b);
    chk(busy, {"R9 busy after start ", name}, int'(busy), 1);
    wait_done(bl);
    chk(bl, "R10 busy low at done", int'(bl), 1);
    chk(!err, {"R8 no error ", name}, int'(err), 0);
    chk(wr_cnt == NENT, "R2 write count", wr_cnt, NENT);
    chk(order_bad == 0 && op_bad == 0, "R2 order/opcode", order_bad + op_bad, 0);
    chk(early_bad == 0, "R6 wait for idle", early_bad, 0);
    check_table(b);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !tbl_we, "R1 reset outputs",
        {busy, done, err, tbl_we}, 0);
  endtask

  task automatic t_boundary_zero();
    run_full(0, 1, "b0");
    chk(mem[255] == 8'd0, "R11 last entry to zero", int'(mem[255]), 0);
    chk(mem[0] == 8'd1, "R11 entry0 in ring", int'(mem[0]), 1);
  endtask

  task automatic t_timeout();
    bit bl;
    lat = 0; stuck = 1'b1;
    clear_model();
    pulse_start(10);
    wait_done(bl);
    chk(err, "R7 err set", int'(err), 1);
    chk(wr_cnt == 1, "R7 abandoned after first", wr_cnt, 1);
    repeat (40) @(negedge clk);
    chk(wr_cnt == 1 && err, "R7 stays quiet, R10 err held", wr_cnt, 1);
    stuck = 1'b0;
  endtask

  task automatic t_timeout_edge();
    bit bl;
    lat = LIMIT + 1; stuck = 1'b0;
    clear_model();
    pulse_start(20);
    wait_done(bl);
    chk(err && wr_cnt == 1, "R7 limit+1 busy polls", wr_cnt, 1);
  endtask

  task automatic t_restart_ignored();
    bit bl;
    lat = 2; stuck = 1'b0;
    clear_model();
    pulse_start(40);
    repeat (100) @(negedge clk);
    pulse_start(7);
    wait_done(bl);
    chk(wr_cnt == NENT && order_bad == 0, "R9 restart ignored", wr_cnt, NENT);
    check_table(40);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_full(16, 0, "b16");
    run_full(200, 2, "b200");
    t_boundary_zero();
    run_full(255, 0, "b255");
    run_full(1, LIMIT, "limit polls");
    t_timeout();
    run_full(5, 0, "after error");
    t_timeout_edge();
    t_restart_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule